// File: doc/BRIEF.md
# EDAC Scrubbing Controller

This block sits between a user port and a single-port register-file RAM. Every word it stores carries an extended Hamming code: 32 data bits, six position-based check bits and one overall parity bit, 39 bits in all. On every read the controller computes a syndrome and acts on it. A word with one flipped bit is corrected. A word with two flipped bits is flagged as uncorrectable. After a correction, a small state machine writes the repaired codeword back to the same address.

A background scrubber uses the cycles the user leaves idle. It reads every address in ascending order, so a single upset is repaired before a second upset in the same word can make it uncorrectable. After each full pass it waits for a programmable number of cycles. The syndrome XOR tree has its own register stage, so the RAM output never feeds the correction logic in the same cycle. A user read therefore takes three cycles. The user port is held off through `ready` while a read or a write-back is in progress.

Top module: `ecc_scrub_ctrl`

## Requirements
- R1: A user write stores a 39-bit word laid out as follows. Bits [31:0] hold the data. Bits [37:32] hold six Hamming check bits. Bit 38 holds overall even parity, so the XOR of all 39 bits is 0. Each check bit is placed as follows. Data bits fill the non-power-of-two codeword positions 3, 5, 6, 7, 9 … 38 in ascending order. Check bit k (word bit 32+k) sits at position 2^k. For each of the six position bits, the XOR over all positions whose index has that bit set is zero.
- R2: A user read is accepted at the clock edge where `req` is high, `we` is low and `ready` is high. `rd_valid` is high for exactly one cycle: the cycle after the third edge, counting the accepting edge. For an error-free word, `rd_data` equals the stored data.
- R3: A single flipped bit anywhere in the 39-bit word is corrected. `rd_data` carries the original data. `corr_pulse` is high for the one cycle in which `rd_valid` is high. `corr_count` rises by one in that same cycle and does not change in any cycle without `corr_pulse`.
- R4: After a correction, the corrected codeword is written back to the same address in the cycle of `corr_pulse`. `ready` is low in that cycle, and the RAM afterwards holds the original codeword.
- R5: A word with two flipped bits returns its stored bits [31:0] unchanged, with `rd_uncorr` high. In that case `corr_pulse` stays low, `corr_count` is unchanged, `ready` is high and the RAM word is left untouched.
- R6: `uncorr_flag` is set by any uncorrectable read, user or scrub, and stays set across later clean reads. A `uncorr_clr` pulse clears it. If a set and a clear fall on the same edge, the set wins.
- R7: `corr_count` saturates at 2^CNT_W−1.
- R8: While `scrub_interval` is non-zero, the scrubber reads addresses in ascending order and wraps after the last one. It repairs single errors exactly as a user read does. While `scrub_interval` is 0, no scrub read is issued.
- R9: After the scrub read of the last address, the next scrub read, of address 0, is issued `scrub_interval`+1 cycles later, for intervals of 2 or more.
- R10: A scrub read starts only in an idle cycle without a user request. A user access that arrives while a scrub operation is in progress waits on `ready` and then completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | User access request, held until accepted |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | User word address |
| wdata | input | DATA_W | User write data |
| ready | output | 1 | Controller can accept a request this cycle |
| rd_valid | output | 1 | User read result valid |
| rd_data | output | DATA_W | User read data (corrected when possible) |
| rd_uncorr | output | 1 | User read hit an uncorrectable word |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W+ECC_W | Codeword to RAM |
| ram_rdata | input | DATA_W+ECC_W | Codeword from RAM, one cycle after a read |
| scrub_interval | input | IVL_W | Cycles of wait after each scrub pass; 0 stops scrubbing |
| corr_pulse | output | 1 | One-cycle pulse per corrected word |
| corr_count | output | CNT_W | Saturating count of corrections |
| uncorr_flag | output | 1 | Sticky uncorrectable-error flag |
| uncorr_clr | input | 1 | Clears `uncorr_flag` |

## Verification
A user read request is raised and lowered at falling edges. After the accepting edge, `rd_valid`, `rd_data`, `rd_uncorr`, `corr_pulse` and the new `corr_count` are due at the third falling edge. The bench counts those edges and requires the result to appear there, not merely within a window. The write-back reaches the RAM array on the edge that ends the `rd_valid` cycle, so the array is inspected one falling edge later. A user write is visible at the first falling edge after acceptance. The scrub-pass gap is measured in cycles between read commands on the RAM port and compared with `scrub_interval`+1.

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl #(
  parameter int DATA_W = 32,
  parameter int ECC_W  = 7,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8,
  parameter int IVL_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    ready,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_uncorr,
  output logic                    ram_en,
  output logic                    ram_we,
  output logic [ADDR_W-1:0]       ram_addr,
  output logic [DATA_W+ECC_W-1:0] ram_wdata,
  input  logic [DATA_W+ECC_W-1:0] ram_rdata,
  input  logic [IVL_W-1:0]        scrub_interval,
  output logic                    corr_pulse,
  output logic [CNT_W-1:0]        corr_count,
  output logic                    uncorr_flag,
  input  logic                    uncorr_clr
);

  localparam int HB   = ECC_W - 1;
  localparam int NPOS = DATA_W + HB;
  localparam logic [HB-1:0] MAXPOS = HB'(NPOS);

  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2, S_WB} state_t;

  function automatic logic [HB-1:0] pos_of(input int idx);
    int k;
    int p;
    k = -1;
    p = 0;
    for (int q = 1; q <= NPOS; q++) begin
      if ((q & (q - 1)) != 0) begin
        k = k + 1;
        if (k == idx) p = q;
      end
    end
    return p[HB-1:0];
  endfunction

  function automatic logic [HB-1:0] calc_chk(input logic [DATA_W-1:0] d);
    logic [HB-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i]) c = c ^ pos_of(i);
    return c;
  endfunction

  function automatic logic [DATA_W+ECC_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [HB-1:0] c;
    c = calc_chk(d);
    return {(^d) ^ (^c), c, d};
  endfunction

  function automatic logic [DATA_W-1:0] repair(input logic [DATA_W-1:0] d,
                                                input logic [HB-1:0] syn);
    logic [DATA_W-1:0] r;
    r = d;
    for (int i = 0; i < DATA_W; i++)
      if (pos_of(i) == syn) r[i] = ~d[i];
    return r;
  endfunction

  state_t              state;
  logic [DATA_W-1:0]   s_data;
  logic [HB-1:0]       s_syn;
  logic                s_par;
  logic                s_user;
  logic [ADDR_W-1:0]   s_addr;
  logic [DATA_W-1:0]   wb_data;
  logic [ADDR_W-1:0]   scrub_ptr;
  logic [IVL_W-1:0]    wait_cnt;

  logic                scrub_go;
  logic                fix_ok;
  logic                bad;
  logic [DATA_W-1:0]   fixed;

  assign ready     = (state == S_IDLE);
  assign scrub_go  = ready && !req && (scrub_interval != '0) && (wait_cnt == '0);
  assign ram_en    = (ready && (req || scrub_go)) || (state == S_WB);
  assign ram_we    = (ready && req && we) || (state == S_WB);
  assign ram_addr  = (state == S_WB) ? s_addr : (req ? addr : scrub_ptr);
  assign ram_wdata = encode((state == S_WB) ? wb_data : wdata);

  assign fix_ok = s_par && ((s_syn == '0) || (s_syn <= MAXPOS));
  assign bad    = ((s_syn != '0) || s_par) && !fix_ok;
  assign fixed  = repair(s_data, s_syn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      s_data      <= '0;
      s_syn       <= '0;
      s_par       <= 1'b0;
      s_user      <= 1'b0;
      s_addr      <= '0;
      wb_data     <= '0;
      scrub_ptr   <= '0;
      wait_cnt    <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      rd_uncorr   <= 1'b0;
      corr_pulse  <= 1'b0;
      corr_count  <= '0;
      uncorr_flag <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
      rd_uncorr  <= 1'b0;
      corr_pulse <= 1'b0;
      if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
      if (uncorr_clr) uncorr_flag <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req) begin
            if (!we) begin
              s_user <= 1'b1;
              s_addr <= addr;
              state  <= S_RD1;
            end
          end else if (scrub_go) begin
            s_user    <= 1'b0;
            s_addr    <= scrub_ptr;
            scrub_ptr <= scrub_ptr + 1'b1;
            if (scrub_ptr == '1) wait_cnt <= scrub_interval;
            state     <= S_RD1;
          end
        end
        S_RD1: begin
          s_data <= ram_rdata[DATA_W-1:0];
          s_syn  <= calc_chk(ram_rdata[DATA_W-1:0]) ^ ram_rdata[DATA_W +: HB];
          s_par  <= ^ram_rdata;
          state  <= S_RD2;
        end
        S_RD2: begin
          rd_valid   <= s_user;
          rd_data    <= fix_ok ? fixed : s_data;
          rd_uncorr  <= s_user && bad;
          corr_pulse <= fix_ok;
          if (fix_ok && (corr_count != '1)) corr_count <= corr_count + 1'b1;
          if (bad) uncorr_flag <= 1'b1;
          if (fix_ok) begin
            wb_data <= fixed;
            state   <= S_WB;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_count_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_pulse |-> $stable(corr_count));

  assert_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    corr_pulse |-> (ram_en && ram_we && !ready && ram_addr == s_addr));

  assert_no_wb_uncorr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_uncorr) |-> (!corr_pulse && ready));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorr_flag && !uncorr_clr) |=> uncorr_flag);

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&corr_count) |=> (&corr_count));

  assert_scrub_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_interval == '0 && ready && !req) |-> !ram_en);

  assert_interval_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt != '0 && ready && !req) |-> !ram_en);

  assert_user_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req && !we) |=> (state == S_RD1 && s_user));

endmodule

// File: tb/ecc_scrub_ctrl_tb.sv
`timescale 1ns/1ps
module ecc_scrub_ctrl_tb;
  localparam int DW = 32;
  localparam int CW = 39;
  localparam int AW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic ready, rd_valid, rd_uncorr, ram_en, ram_we, corr_pulse, uncorr_flag;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] ram_addr;
  logic [CW-1:0] ram_wdata, ram_rdata;
  logic [7:0] scrub_interval = 0;
  logic [7:0] corr_count;
  logic uncorr_clr = 0;

  logic inj_en = 0;
  logic [AW-1:0] inj_addr = 0;
  logic [CW-1:0] inj_mask = 0;
  logic [CW-1:0] mem [16];

  int checks = 0, fails = 0, cyc = 0;
  int nreads = 0, prev_addr = -1, prev_t = 0, last_gap = -1, ord_err = 0;
  logic ord_on = 0;
  logic [DW-1:0] dat [16];

  always #2 clk = ~clk;

  ecc_scrub_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_uncorr(rd_uncorr),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .scrub_interval(scrub_interval), .corr_pulse(corr_pulse),
    .corr_count(corr_count), .uncorr_flag(uncorr_flag), .uncorr_clr(uncorr_clr)
  );

  always @(posedge clk) begin
    cyc++;
    if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else begin
        ram_rdata <= mem[ram_addr];
        nreads++;
        if (ord_on && prev_addr >= 0 && int'(ram_addr) != ((prev_addr + 1) % 16)) ord_err++;
        if (ram_addr == 0 && prev_addr == 15) last_gap = cyc - prev_t;
        prev_addr = int'(ram_addr);
        prev_t = cyc;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    summary();
    $finish;
  end

  function automatic bit code_ok(input logic [CW-1:0] w);
    int syn = 0, k = 0, lg = 0;
    bit b;
    for (int q = 1; q <= 38; q++) begin
      if ((q & (q - 1)) == 0) begin b = w[32 + lg]; lg++; end
      else begin b = w[k]; k++; end
      if (b) syn = syn ^ q;
    end
    return (syn == 0) && ((^w) == 1'b0);
  endfunction

  task automatic user_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    dat[a] = d;
  endtask

  task automatic user_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                           output logic uc, output logic cp, output logic rdy, output int lat);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
    lat = 1;
    while (!rd_valid && lat < 10) begin @(negedge clk); lat++; end
    d = rd_data; uc = rd_uncorr; cp = corr_pulse; rdy = ready;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [CW-1:0] m);
    @(negedge clk);
    inj_en = 1; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_en = 0;
  endtask

  initial begin
    logic [DW-1:0] d;
    logic uc, cp, rdy;
    int lat, expc, a, n0;
    logic [CW-1:0] w, fw;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready === 1'b1, "R2 reset ready", ready, 1);
    chk(rd_valid === 1'b0 && corr_pulse === 1'b0, "R3 reset pulses", {rd_valid, corr_pulse}, 0);
    chk(corr_count === 8'd0, "R7 reset count", corr_count, 0);
    chk(uncorr_flag === 1'b0, "R6 reset flag", uncorr_flag, 0);

    for (int i = 0; i < 16; i++) begin
      user_write(i[AW-1:0], (32'h9E3779B9 * (i + 1)) ^ {i[7:0], 24'h00F0F0});
      @(negedge clk);
      chk(mem[i][31:0] == dat[i], "R1 data field", mem[i][31:0], dat[i]);
      chk(code_ok(mem[i]), "R1 check bits", mem[i], 0);
    end
    user_write(4'd0, 32'h0); chk(code_ok(mem[0]) && mem[0] == 0, "R1 zero word", mem[0], 0);
    user_write(4'd1, 32'hFFFFFFFF); chk(code_ok(mem[1]), "R1 ones word", mem[1], 0);

    for (int i = 0; i < 16; i++) begin
      user_read(i[AW-1:0], d, uc, cp, rdy, lat);
      chk(lat == 3, "R2 latency", lat, 3);
      chk(d == dat[i] && !uc && !cp, "R2 clean read", d, dat[i]);
    end

    expc = 0;
    for (int b = 0; b < CW; b++) begin
      a = b % 16;
      w = mem[a];
      inject(a[AW-1:0], 39'd1 << b);
      user_read(a[AW-1:0], d, uc, cp, rdy, lat);
      expc++;
      chk(lat == 3, "R2 latency on error", lat, 3);
      chk(d == dat[a] && !uc, "R3 corrected data", d, dat[a]);
      chk(cp === 1'b1, "R3 corr pulse", cp, 1);
      chk(corr_count == expc[7:0], "R3 count", corr_count, expc);
      chk(rdy === 1'b0, "R4 ready low in write-back", rdy, 0);
      @(negedge clk);
      chk(mem[a] == w, "R4 write-back word", mem[a], w);
      chk(corr_pulse === 1'b0, "R3 pulse one cycle", corr_pulse, 0);
    end

    for (int i = 0; i < CW; i++)
      for (int j = i + 1; j < CW; j++) begin
        a = (i + j) % 16;
        w = mem[a];
        fw = w ^ (39'd1 << i) ^ (39'd1 << j);
        inject(a[AW-1:0], fw ^ w);
        user_read(a[AW-1:0], d, uc, cp, rdy, lat);
        chk(uc === 1'b1 && lat == 3, "R5 uncorrectable flag", uc, 1);
        chk(d == fw[31:0], "R5 raw data", d, fw[31:0]);
        chk(!cp && rdy && corr_count == expc[7:0], "R5 no correction", corr_count, expc);
        chk(uncorr_flag === 1'b1, "R6 flag set", uncorr_flag, 1);
        @(negedge clk);
        chk(mem[a] == fw, "R5 no write-back", mem[a], fw);
        inject(a[AW-1:0], fw ^ w);
      end

    user_read(4'd5, d, uc, cp, rdy, lat);
    chk(d == dat[5] && uncorr_flag === 1'b1, "R6 flag sticky", uncorr_flag, 1);
    @(negedge clk); uncorr_clr = 1; @(negedge clk); uncorr_clr = 0;
    chk(uncorr_flag === 1'b0, "R6 flag cleared", uncorr_flag, 0);

    n0 = nreads;
    repeat (100) @(negedge clk);
    chk(nreads == n0, "R8 scrub disabled", nreads - n0, 0);

    inject(4'd3, 39'd1 << 5);
    inject(4'd9, 39'd1 << 36);
    w = mem[3] ^ (39'd1 << 5);
    fw = mem[9] ^ (39'd1 << 36);
    @(negedge clk);
    ord_on = 1; prev_addr = -1; ord_err = 0; last_gap = -1;
    scrub_interval = 8'd20;
    repeat (300) @(negedge clk);
    scrub_interval = 8'd0;
    repeat (6) @(negedge clk);
    ord_on = 0;
    expc += 2;
    chk(mem[3] == w && mem[9] == fw, "R8 scrub repaired", mem[3], w);
    chk(corr_count == expc[7:0], "R8 scrub count", corr_count, expc);
    chk(ord_err == 0, "R8 ascending order", ord_err, 0);
    chk(last_gap == 21, "R9 pass gap", last_gap, 21);

    scrub_interval = 8'd2;
    for (int i = 0; i < 24; i++) begin
      a = (i * 7) % 16;
      user_write(a[AW-1:0], 32'hC0DE0000 + i * 32'h1111);
      user_read(a[AW-1:0], d, uc, cp, rdy, lat);
      chk(d == dat[a] && lat == 3 && !uc, "R10 user during scrub", d, dat[a]);
    end
    scrub_interval = 8'd0;
    repeat (6) @(negedge clk);

    for (int n = 0; n < 240; n++) begin
      a = n % 16;
      inject(a[AW-1:0], 39'd1 << (n % CW));
      user_read(a[AW-1:0], d, uc, cp, rdy, lat);
      expc = (expc < 255) ? expc + 1 : 255;
      chk(d == dat[a] && corr_count == expc[7:0], "R7 saturating count", corr_count, expc);
    end
    chk(corr_count == 8'd255, "R7 saturated", corr_count, 255);

    summary();
    $finish;
  end
endmodule